// File: doc/BRIEF.md
# Programmable Flat Race-Tree Evaluator

This block classifies one sample with a single decision tree that has been flattened into independent node tests. Features arrive delay-coded: each feature is a wire that rises once, and the number of clock cycles between the race start and that rise is the feature's value. One start pulse launches a shared threshold shift register. Tap `t` of that register rises in race cycle `t`. Every tree node has one inhibit gate. The threshold edge is its inhibiting input and a routed feature edge is its data input, so the node passes exactly when the feature is not larger than the threshold. The number of bits in a value does not change this: each node is still one gate.

Two crossbars are set through a small configuration port. One picks which feature feeds each node and the other picks which threshold tap feeds each node. The same port loads a per-leaf vote word. Once the largest threshold time has passed, the node outputs are captured as a plain binary vector. An AND/inverter decoder maps that vector to the single leaf whose path it satisfies. The leaf index then reads the vote memory, and the index, the vote and the captured decisions are presented together with a one-cycle done strobe. A new start pulse clears all race state, and it does so even in the middle of a race.

Top module: `race_tree_eval`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `done` and `busy` are 0 and `leaf_idx`, `vote` and `node_vec` are all zero.
- R2: Race cycle 0 is the cycle that follows the edge at which `start` is sampled. Node n decides true when its routed feature first rises in a race cycle at or before its routed tap index (tap t rises in race cycle t). A feature that arrives in the same cycle as the threshold therefore counts as true.
- R3: A feature that has not risen by race cycle 2^TW-1 is larger than every threshold, and every node it feeds decides false. A rise after that cycle has no effect on the result.
- R4: A configuration write with `cfg_kind`=0 and `cfg_idx`=n routes feature number `cfg_data[FSEL_W-1:0]` to node n. Any feature may feed any node, and several nodes may share one feature.
- R5: A configuration write with `cfg_kind`=1 and `cfg_idx`=n routes threshold tap `cfg_data[TW-1:0]` to node n.
- R6: Nodes use heap numbering: the root is 0, and the children of node n are 2n+1 (taken when n is true) and 2n+2 (taken when n is false). `leaf_idx` lists the root-to-leaf outcomes from MSB (root) to LSB, with 0 for a true branch and 1 for a false branch. Nodes off the path do not affect it.
- R7: A configuration write with `cfg_kind`=2 stores `cfg_data` as the vote of leaf `cfg_idx`. `vote` shows the stored word of the decided leaf.
- R8: `done` is high for exactly one cycle, in race cycle 2^TW+1. That is the cycle after the edge on which the decisions are captured.
- R9: `leaf_idx`, `vote` and `node_vec` change only in a cycle where `done` is high. They hold their values through later idle cycles and through configuration writes. `node_vec` bit n is the captured decision of node n.
- R10: A `start` pulse during a race aborts it. No `done` is produced for the aborted race, and the next result reflects only the new race.
- R11: `busy` is high from the edge that samples `start` until the edge that raises `done`.
- R12: A configuration write with `cfg_kind`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears race state and begins a race |
| feat_edge | input | NFEAT | Delay-coded feature wires; each rises once per race and stays high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_kind | input | 2 | Write target: 0 feature route, 1 threshold route, 2 leaf vote, 3 none |
| cfg_idx | input | DEPTH | Node or leaf number written |
| cfg_data | input | VOTE_W | Write data; low bits used for routes |
| busy | output | 1 | Race or result decode in progress |
| done | output | 1 | One-cycle strobe: result valid |
| leaf_idx | output | DEPTH | Decided leaf |
| vote | output | VOTE_W | Vote word of the decided leaf |
| node_vec | output | 2^DEPTH-1 | Captured node decisions |

## Verification
The bench sweeps every combination of arrival times for all four features, including a rise that comes too late, under two routing setups. These include one where two nodes share a feature and one where a node uses tap 0. A gate that let the threshold win ties, or that treated a late feature as passing, would produce wrong node vectors. An off-by-one in the capture time would make late arrivals leak into the decision. A decoder with swapped branch polarity would report the mirrored leaf. The bench also restarts a race midway, which exposes a design that lets the stale race finish. It writes a vote while a result is being held, which catches an output that is read from memory live instead of being registered. Finally, it issues a write with the unused kind, which catches decode aliasing onto the route or vote registers.

// File: rtl/rt_pkg.sv
// Shared definitions for the race-tree evaluator: configuration target
// codes and a width helper. Assumes nothing beyond IEEE 1800-2017.
package rt_pkg;

    typedef enum logic [1:0] {
        CFG_FSEL = 2'd0,
        CFG_TSEL = 2'd1,
        CFG_VOTE = 2'd2,
        CFG_NONE = 2'd3
    } cfg_kind_e;

    // Width of a selector over n choices, at least one bit.
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rt_thresh_gen.sv
// Threshold edge generator: a shift register that fills with ones.
// Start loads a one into tap 0; every running cycle after that, the next
// tap rises, so tap t rises t cycles after tap 0. Assumes TAPS >= 2.
module rt_thresh_gen #(
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    output logic [TAPS-1:0] taps
);

    // Load on start, then shift a one upward each running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (start) begin
            taps <= TAPS'(1);
        end else if (run) begin
            taps <= {taps[TAPS-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/rt_inhibit.sv
// One temporal inhibit gate. The data edge passes unless the inhibiting
// edge was seen high in an earlier cycle while data was still low; ties
// pass. Clear re-arms the gate for a new race.
module rt_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic data_in,
    input  logic inhibit_in,
    output logic pass
);

    logic blocked;

    // Remember that the inhibitor won the race; clear on a new race.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (clr) begin
            blocked <= 1'b0;
        end else if (inhibit_in && !data_in) begin
            blocked <= 1'b1;
        end
    end

    assign pass = data_in && !blocked;

endmodule

// File: rtl/rt_cfg_regs.sv
// Configuration store: feature route and threshold route per node, vote
// word per leaf. Writes with an unused kind, or a node number past the
// last node, are dropped. Assumes VOTE_W >= FSEL_W and VOTE_W >= TW.
module rt_cfg_regs
    import rt_pkg::*;
#(
    parameter int NODES  = 3,
    parameter int LEAVES = 4,
    parameter int IDX_W  = 2,
    parameter int FSEL_W = 2,
    parameter int TW     = 2,
    parameter int VOTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [1:0]                     kind,
    input  logic [IDX_W-1:0]               idx,
    input  logic [VOTE_W-1:0]              data,
    output logic [NODES-1:0][FSEL_W-1:0]   fsel,
    output logic [NODES-1:0][TW-1:0]       tsel,
    output logic [LEAVES-1:0][VOTE_W-1:0]  votes
);

    // Route registers, one pair per node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel <= '0;
            tsel <= '0;
        end else if (we) begin
            for (int n = 0; n < NODES; n++) begin
                if (idx == IDX_W'(n)) begin
                    if (kind == CFG_FSEL) fsel[n] <= data[FSEL_W-1:0];
                    if (kind == CFG_TSEL) tsel[n] <= data[TW-1:0];
                end
            end
        end
    end

    // Vote memory, one word per leaf.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            votes <= '0;
        end else if (we && kind == CFG_VOTE) begin
            for (int l = 0; l < LEAVES; l++) begin
                if (idx == IDX_W'(l)) votes[l] <= data;
            end
        end
    end

endmodule

// File: rtl/rt_leaf_decoder.sv
// Flat-tree leaf decoder built from AND terms and inverters. Each leaf
// matches the fixed outcomes of the nodes on its root path (heap order,
// true branch = 2n+1); the single matching leaf is encoded as an index
// whose MSB is the root outcome (0 = true). Off-path nodes are ignored.
module rt_leaf_decoder #(
    parameter int DEPTH = 2,
    localparam int NODES  = (1 << DEPTH) - 1,
    localparam int LEAVES = 1 << DEPTH
) (
    input  logic [NODES-1:0] dec,
    output logic [DEPTH-1:0] leaf
);

    logic [LEAVES-1:0][DEPTH-1:0] term;
    logic [LEAVES-1:0]            hit;

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        for (genvar d = 0; d < DEPTH; d++) begin : g_lvl
            localparam int NODE = ((1 << d) - 1) + (l >> (DEPTH - d));
            localparam bit WANT_FALSE = ((l >> (DEPTH - 1 - d)) & 1) != 0;
            if (WANT_FALSE) begin : g_inv
                assign term[l][d] = ~dec[NODE];
            end else begin : g_dir
                assign term[l][d] = dec[NODE];
            end
        end
        assign hit[l] = &term[l];
    end

    // Encode the matching leaf as a binary index.
    always_comb begin
        leaf = '0;
        for (int l = 0; l < LEAVES; l++) begin
            if (hit[l]) leaf = leaf | l[DEPTH-1:0];
        end
    end

endmodule

// File: rtl/race_tree_eval.sv
// Programmable flat race-tree evaluator. Start launches the threshold
// shift register and re-arms every node gate. Features are delay-coded
// edges held high once risen. After race cycle 2^TW-1 the node outputs are
// captured; one cycle later the decoded leaf, its vote and the captured
// decisions are registered out with a one-cycle done strobe.
module race_tree_eval
    import rt_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int NFEAT  = 4,
    parameter int TW     = 2,
    parameter int VOTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NFEAT-1:0]        feat_edge,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_kind,
    input  logic [DEPTH-1:0]        cfg_idx,
    input  logic [VOTE_W-1:0]       cfg_data,
    output logic                    busy,
    output logic                    done,
    output logic [DEPTH-1:0]        leaf_idx,
    output logic [VOTE_W-1:0]       vote,
    output logic [(1<<DEPTH)-2:0]   node_vec
);

    localparam int NODES  = (1 << DEPTH) - 1;
    localparam int LEAVES = 1 << DEPTH;
    localparam int TAPS   = 1 << TW;
    localparam int TMAX   = TAPS - 1;
    localparam int FSEL_W = sel_width(NFEAT);

    logic [NODES-1:0][FSEL_W-1:0]  fsel;
    logic [NODES-1:0][TW-1:0]      tsel;
    logic [LEAVES-1:0][VOTE_W-1:0] votes;
    logic [TAPS-1:0]               taps;
    logic [NODES-1:0]              feat_r;
    logic [NODES-1:0]              thr_r;
    logic [NODES-1:0]              pass_vec;
    logic [NODES-1:0]              samp;
    logic [DEPTH-1:0]              leaf_c;
    logic                          running;
    logic                          pend;
    logic                          last;
    logic [TW-1:0]                 step;

    rt_cfg_regs #(
        .NODES (NODES),
        .LEAVES(LEAVES),
        .IDX_W (DEPTH),
        .FSEL_W(FSEL_W),
        .TW    (TW),
        .VOTE_W(VOTE_W)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .kind (cfg_kind),
        .idx  (cfg_idx),
        .data (cfg_data),
        .fsel (fsel),
        .tsel (tsel),
        .votes(votes)
    );

    rt_thresh_gen #(.TAPS(TAPS)) u_thr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .run  (running),
        .taps (taps)
    );

    // Two crossbars and one inhibit gate per node.
    for (genvar n = 0; n < NODES; n++) begin : g_node
        assign feat_r[n] = feat_edge[fsel[n]];
        assign thr_r[n]  = taps[tsel[n]];
        rt_inhibit u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (start),
            .data_in   (feat_r[n]),
            .inhibit_in(thr_r[n]),
            .pass      (pass_vec[n])
        );
    end

    assign last = running && (step == TW'(TMAX)) && !start;
    assign busy = running || pend;

    // Race sequencer: count race cycles, hand over to decode after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pend    <= 1'b0;
            step    <= '0;
        end else if (start) begin
            running <= 1'b1;
            pend    <= 1'b0;
            step    <= '0;
        end else if (last) begin
            running <= 1'b0;
            pend    <= 1'b1;
        end else if (running) begin
            step    <= step + 1'b1;
        end else begin
            pend    <= 1'b0;
        end
    end

    // Capture the settled node decisions as a binary vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp <= '0;
        end else if (last) begin
            samp <= pass_vec;
        end
    end

    rt_leaf_decoder #(.DEPTH(DEPTH)) u_dec (
        .dec (samp),
        .leaf(leaf_c)
    );

    // Register the leaf, its vote and the decisions with the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            leaf_idx <= '0;
            vote     <= '0;
            node_vec <= '0;
        end else begin
            done <= pend && !start;
            if (pend && !start) begin
                leaf_idx <= leaf_c;
                vote     <= votes[leaf_c];
                node_vec <= samp;
            end
        end
    end

endmodule

// File: rtl/rt_eval_chk.sv
// Protocol checker for race_tree_eval, bound to every instance. Tracks the
// cycles since the last start with its own counter and checks strobe
// timing, busy coverage and result holding.
module rt_eval_chk #(
    parameter int DEPTH  = 2,
    parameter int TW     = 2,
    parameter int VOTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DEPTH-1:0]  leaf_idx,
    input logic [VOTE_W-1:0] vote
);

    localparam int TAPS = 1 << TW;
    localparam int LW   = $clog2(TAPS + 4) + 1;

    logic [LW-1:0] lat;

    // Count cycles since start was sampled; idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (start) begin
            lat <= LW'(1);
        end else if (done) begin
            lat <= '0;
        end else if (lat != '0) begin
            lat <= lat + 1'b1;
        end
    end

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == LW'(TAPS + 2)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !done);

    // R9
    leaf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(leaf_idx) |-> done);

    // R9
    vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vote) |-> done);

endmodule

bind race_tree_eval rt_eval_chk #(
    .DEPTH (DEPTH),
    .TW    (TW),
    .VOTE_W(VOTE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .leaf_idx(leaf_idx),
    .vote    (vote)
);

// File: tb/race_tree_eval_test.sv
// Self-checking bench: sweeps every arrival pattern of all features under
// two routing setups, plus restart, hold and unused-write cases.
module race_tree_eval_test;

    localparam int DEPTH  = 2;
    localparam int NFEAT  = 4;
    localparam int TW     = 2;
    localparam int VOTE_W = 8;
    localparam int NODES  = (1 << DEPTH) - 1;
    localparam int LEAVES = 1 << DEPTH;
    localparam int TAPS   = 1 << TW;
    localparam int NEVER  = TAPS;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic [NFEAT-1:0]    feat_edge;
    logic                cfg_we;
    logic [1:0]          cfg_kind;
    logic [DEPTH-1:0]    cfg_idx;
    logic [VOTE_W-1:0]   cfg_data;
    logic                busy;
    logic                done;
    logic [DEPTH-1:0]    leaf_idx;
    logic [VOTE_W-1:0]   vote;
    logic [NODES-1:0]    node_vec;

    int checks = 0;
    int errors = 0;
    int fv [NFEAT];
    int fs [NODES];
    int ts [NODES];
    int vt [LEAVES];
    int exp_vec;
    int exp_leaf;

    always #10 clk = ~clk;

    race_tree_eval #(
        .DEPTH(DEPTH), .NFEAT(NFEAT), .TW(TW), .VOTE_W(VOTE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .feat_edge(feat_edge),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .busy(busy), .done(done),
        .leaf_idx(leaf_idx), .vote(vote), .node_vec(node_vec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int kind, input int idx, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_kind = kind[1:0];
        cfg_idx  = idx[DEPTH-1:0];
        cfg_data = data[VOTE_W-1:0];
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic load_cfg();
        for (int n = 0; n < NODES; n++) begin
            cfg_write(0, n, fs[n]);
            cfg_write(1, n, ts[n]);
        end
        for (int l = 0; l < LEAVES; l++) cfg_write(2, l, vt[l]);
    endtask

    // Expected decisions and leaf from the heap walk of R2, R3 and R6.
    task automatic compute_expected();
        int n;
        exp_vec  = 0;
        exp_leaf = 0;
        for (int k = 0; k < NODES; k++)
            if (fv[fs[k]] <= ts[k]) exp_vec = exp_vec | (1 << k);
        n = 0;
        for (int d = 0; d < DEPTH; d++) begin
            if (((exp_vec >> n) & 1) != 0) begin
                exp_leaf = exp_leaf << 1;
                n = 2 * n + 1;
            end else begin
                exp_leaf = (exp_leaf << 1) | 1;
                n = 2 * n + 2;
            end
        end
    endtask

    task automatic run_race();
        int seen;
        compute_expected();
        @(negedge clk);
        start     = 1'b1;
        feat_edge = '0;
        @(negedge clk);
        start = 1'b0;
        seen  = -1;
        chk(busy === 1'b1, "R11", "busy after start", int'(busy), 1);
        for (int c = 0; c <= TAPS + 2; c++) begin
            if (c > 0) @(negedge clk);
            if (done === 1'b1 && seen < 0) begin
                seen = c;
                chk(busy === 1'b0, "R11", "busy in done cycle", int'(busy), 0);
                chk(int'(node_vec) == exp_vec, "R2 R3 R4 R5", "node_vec",
                    int'(node_vec), exp_vec);
                chk(int'(leaf_idx) == exp_leaf, "R6", "leaf_idx",
                    int'(leaf_idx), exp_leaf);
                chk(int'(vote) == vt[exp_leaf], "R7", "vote",
                    int'(vote), vt[exp_leaf]);
            end else if (c == TAPS + 2) begin
                chk(done === 1'b0, "R8", "done one cycle", int'(done), 0);
            end
            for (int f = 0; f < NFEAT; f++) feat_edge[f] = (fv[f] <= c);
        end
        chk(seen == TAPS + 1, "R8 R10", "done race cycle", seen, TAPS + 1);
    endtask

    task automatic sweep();
        for (int a = 0; a <= NEVER; a++)
            for (int b = 0; b <= NEVER; b++)
                for (int c = 0; c <= NEVER; c++)
                    for (int d = 0; d <= NEVER; d++) begin
                        fv[0] = a; fv[1] = b; fv[2] = c; fv[3] = d;
                        run_race();
                    end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; feat_edge = '0;
        cfg_we = 1'b0; cfg_kind = '0; cfg_idx = '0; cfg_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done === 1'b0 && busy === 1'b0, "R1", "strobes in reset",
            int'({done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(leaf_idx === '0 && vote === '0 && node_vec === '0, "R1",
            "outputs after reset", int'(vote), 0);
        chk(done === 1'b0 && busy === 1'b0, "R1", "strobes after reset",
            int'({done, busy}), 0);

        // Setup A: distinct features, tap 0 on node 2.
        fs = '{0, 1, 2}; ts = '{1, 2, 0}; vt = '{11, 22, 33, 44};
        load_cfg();
        sweep();

        // Setup B: two nodes share one feature (R4), maximum tap (R5).
        fs = '{3, 3, 0}; ts = '{3, 0, 2}; vt = '{129, 146, 163, 180};
        load_cfg();
        sweep();

        // R10: restart mid-race; the new race alone decides.
        fv = '{0, 0, 0, 0};
        @(negedge clk);
        start = 1'b1; feat_edge = '0;
        @(negedge clk);
        start = 1'b0; feat_edge = '1;
        @(negedge clk);
        chk(done === 1'b0, "R10", "no early done", int'(done), 0);
        fv = '{NEVER, NEVER, NEVER, NEVER};
        run_race();

        // R9: results hold while idle and across a vote write.
        cfg_write(2, exp_leaf, 7);
        repeat (2) @(negedge clk);
        chk(int'(vote) == vt[exp_leaf], "R9", "vote held", int'(vote),
            vt[exp_leaf]);
        chk(int'(leaf_idx) == exp_leaf, "R9", "leaf held", int'(leaf_idx),
            exp_leaf);
        chk(int'(node_vec) == exp_vec, "R9", "node_vec held",
            int'(node_vec), exp_vec);
        vt[exp_leaf] = 7;

        // R12: unused kind leaves routes and votes untouched.
        for (int k = 0; k < LEAVES; k++) cfg_write(3, k, 255);
        fv = '{0, 0, 0, 0};
        run_race();
        fv = '{NEVER, 1, NEVER, 2};
        run_race();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule